// File: doc/BRIEF.md
# Vertical-First Element Step Controller

This block keeps the source and destination element indices used by a vector unit running in vertical-first mode. In this mode, an ordinary vector instruction works on only one element: the element at the current indices. The program counter then moves on as it would for a scalar instruction. The indices change only when an explicit step command arrives. On a step command, each index moves forward to the next element that its own predicate mask enables. Each sub-vector group of two, three or four parts counts as one element, so the indices count groups and never parts of a group.

A step command can also produce a 4-bit condition report. The report gives the end-of-loop flags of one of four external remap schedules, selected by the command's immediate, and a flag that is set when no enabled element remains below the vector length. When the command names a nonzero destination register, immediates 5 and 6 return the updated source or destination index through a one-cycle write pulse. The index and report registers are updated at the clock edge that samples the command.

Top module: `vfstep_ctrl`

## Requirements
- R1: After reset, `srcstep` and `dststep` are 0, `cr0` is 4'b0000, `rt_we` is 0 and `rt_val` is 0.
- R2: A command is a step command only when `cmd_valid`=1, `cmd_vf`=1, `cmd_vs`=0 and `cmd_ms`=0. In every other cycle, `srcstep` and `dststep` keep their values.
- R3: A step command updates `srcstep` at the next clock edge. The new value is the lowest index i for which i > `srcstep`, i < `vl` and `src_mask[i]`=1. `dststep` is updated the same way, independently, using `dst_mask`.
- R4: If either index has no such next index (this includes `vl`=0), the step command sets both `srcstep` and `dststep` to 0. The vector-length-reached flag `cr0[0]` is then 1 in the report of that command. Otherwise `cr0[0]` is 0.
- R5: `cr0` is loaded only by a step command with `cmd_rc`=1. In every other cycle it keeps its value.
- R6: In a report, an immediate k in the range 1 to 4 selects remap state s=k-1. Its flags are read from `remap_end[3s+2:3s]`, ordered outer, middle, inner, and are placed as follows: inner goes to `cr0[1]`, outer goes to `cr0[2]`, middle goes to `cr0[3]`. For any other immediate, `cr0[3:1]` is 0.
- R7: A step command with `cmd_rt_nz`=1 and immediate 5 makes `rt_we` equal 1 for the next cycle, with `rt_val` set to the new `srcstep` zero-extended. Immediate 6 does the same with the new `dststep`. In all other cases `rt_we` is 0 and `rt_val` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_vf | input | 1 | Vertical-first flag of the command |
| cmd_vs | input | 1 | Length-setting flag of the command |
| cmd_ms | input | 1 | Maximum-length-setting flag of the command |
| cmd_rc | input | 1 | Request a condition report |
| cmd_rt_nz | input | 1 | Destination register of the command is nonzero |
| cmd_imm | input | 7 | Immediate selector |
| vl | input | 7 | Current vector length, 0 to 64 |
| src_mask | input | 64 | Source predicate mask, one bit per element |
| dst_mask | input | 64 | Destination predicate mask, one bit per element |
| remap_end | input | 12 | Loop-end flags, three per remap state |
| srcstep | output | 6 | Current source element index |
| dststep | output | 6 | Current destination element index |
| cr0 | output | 4 | Condition report |
| rt_we | output | 1 | Index-return write pulse |
| rt_val | output | 64 | Returned index value |

## Verification
Two situations are hard to reach from the ports. In the first, one mask runs out of enabled elements while the other still has some, and that single exhaustion must reset both indices together. In the second, the last index, 63, is reached with `vl`=64. The stimulus runs in phases. Each phase holds fixed mask densities and a fixed vector length: one phase has a full source mask and a sparse destination mask, another has only bits 0 and 63 set, and others use empty masks or `vl`=0. Within each phase, long runs of mostly-step commands walk the indices to the end and back to zero many times.

// File: rtl/vfstep_pkg.sv
package vfstep_pkg;
  localparam int unsigned IMM_W      = 7;
  localparam int unsigned FLAGS_PER  = 3;
  localparam int unsigned IMM_SRC    = 5;
  localparam int unsigned IMM_DST    = 6;

  typedef struct packed {
    logic middle;
    logic outer;
    logic inner;
    logic vl_end;
  } cr_t;

  function automatic logic imm_selects_remap(input logic [IMM_W-1:0] imm, input int unsigned nremap);
    return (int'(imm) >= 1) && (int'(imm) <= int'(nremap));
  endfunction
endpackage

// File: rtl/vfs_next_finder.sv
module vfs_next_finder #(
  parameter int unsigned MAXVL = 64
) (
  input  logic [MAXVL-1:0]         mask,
  input  logic [$clog2(MAXVL):0]   vl,
  input  logic [$clog2(MAXVL)-1:0] cur,
  output logic [$clog2(MAXVL)-1:0] nxt,
  output logic                     found
);
  localparam int unsigned SW = $clog2(MAXVL);

  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int i = MAXVL - 1; i >= 0; i--) begin
      if (mask[i] && (i > int'(cur)) && (i < int'(vl))) begin
        found = 1'b1;
        nxt   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/vfs_cr_sel.sv
module vfs_cr_sel
  import vfstep_pkg::*;
#(
  parameter int unsigned NREMAP = 4
) (
  input  logic [IMM_W-1:0]            imm,
  input  logic [FLAGS_PER*NREMAP-1:0] remap_end,
  input  logic                        vl_end,
  output cr_t                         cr
);
  logic [FLAGS_PER-1:0] picked;

  always_comb begin
    picked = '0;
    for (int s = 0; s < int'(NREMAP); s++) begin
      if (imm_selects_remap(imm, NREMAP) && (int'(imm) == s + 1))
        picked = remap_end[s*FLAGS_PER +: FLAGS_PER];
    end
    cr.inner  = picked[0];
    cr.middle = picked[1];
    cr.outer  = picked[2];
    cr.vl_end = vl_end;
  end
endmodule

// File: rtl/vfstep_ctrl.sv
module vfstep_ctrl
  import vfstep_pkg::*;
#(
  parameter int unsigned MAXVL  = 64,
  parameter int unsigned NREMAP = 4,
  parameter int unsigned RT_W   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_valid,
  input  logic                            cmd_vf,
  input  logic                            cmd_vs,
  input  logic                            cmd_ms,
  input  logic                            cmd_rc,
  input  logic                            cmd_rt_nz,
  input  logic [6:0]                      cmd_imm,
  input  logic [$clog2(MAXVL):0]          vl,
  input  logic [MAXVL-1:0]                src_mask,
  input  logic [MAXVL-1:0]                dst_mask,
  input  logic [3*NREMAP-1:0]             remap_end,
  output logic [$clog2(MAXVL)-1:0]        srcstep,
  output logic [$clog2(MAXVL)-1:0]        dststep,
  output logic [3:0]                      cr0,
  output logic                            rt_we,
  output logic [RT_W-1:0]                 rt_val
);
  localparam int unsigned SW = $clog2(MAXVL);

  // named internal events, observed by the bound checker
  logic          step_fire;
  logic          vl_end_w;
  logic          src_found, dst_found;
  logic [SW-1:0] src_nxt, dst_nxt;
  logic [SW-1:0] src_new, dst_new;
  logic          ret_fire;
  cr_t           cr_w;

  assign step_fire = cmd_valid & cmd_vf & ~cmd_vs & ~cmd_ms;

  vfs_next_finder #(.MAXVL(MAXVL)) u_src_find (
    .mask(src_mask), .vl(vl), .cur(srcstep), .nxt(src_nxt), .found(src_found)
  );

  vfs_next_finder #(.MAXVL(MAXVL)) u_dst_find (
    .mask(dst_mask), .vl(vl), .cur(dststep), .nxt(dst_nxt), .found(dst_found)
  );

  assign vl_end_w = ~(src_found & dst_found);
  assign src_new  = vl_end_w ? '0 : src_nxt;
  assign dst_new  = vl_end_w ? '0 : dst_nxt;

  vfs_cr_sel #(.NREMAP(NREMAP)) u_cr (
    .imm(cmd_imm), .remap_end(remap_end), .vl_end(vl_end_w), .cr(cr_w)
  );

  assign ret_fire = step_fire & cmd_rt_nz &
                    ((int'(cmd_imm) == int'(IMM_SRC)) || (int'(cmd_imm) == int'(IMM_DST)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcstep <= '0;
      dststep <= '0;
      cr0     <= '0;
      rt_we   <= 1'b0;
      rt_val  <= '0;
    end else begin
      rt_we <= ret_fire;
      if (step_fire) begin
        srcstep <= src_new;
        dststep <= dst_new;
        if (cmd_rc) cr0 <= cr_w;
      end
      if (ret_fire)
        rt_val <= (int'(cmd_imm) == int'(IMM_SRC)) ? RT_W'(src_new) : RT_W'(dst_new);
    end
  end
endmodule

// File: rtl/vfstep_ctrl_chk.sv
module vfstep_ctrl_chk #(
  parameter int unsigned MAXVL = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     step_fire,
  input logic                     vl_end_w,
  input logic                     cmd_rc,
  input logic [$clog2(MAXVL)-1:0] srcstep,
  input logic [$clog2(MAXVL)-1:0] dststep,
  input logic [3:0]               cr0,
  input logic                     rt_we
);
  a_r2_hold_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> ($stable(srcstep) && $stable(dststep)));

  a_r3_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !vl_end_w) |=> ((srcstep > $past(srcstep)) && (dststep > $past(dststep))));

  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && vl_end_w) |=> ((srcstep == '0) && (dststep == '0)));

  a_r4_vl_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && cmd_rc) |=> (cr0[0] == $past(vl_end_w)));

  a_r5_cr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_fire && cmd_rc) |=> $stable(cr0));

  a_r7_pulse_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> $past(step_fire));
endmodule

bind vfstep_ctrl vfstep_ctrl_chk #(.MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_fire(step_fire), .vl_end_w(vl_end_w),
  .cmd_rc(cmd_rc), .srcstep(srcstep), .dststep(dststep), .cr0(cr0), .rt_we(rt_we)
);

// File: tb/tb_vfstep_ctrl.sv
`timescale 1ns/1ps
module tb_vfstep_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_vf = 0, cmd_vs = 0, cmd_ms = 0, cmd_rc = 0, cmd_rt_nz = 0;
  logic [6:0]  cmd_imm = '0;
  logic [6:0]  vl = '0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic [11:0] remap_end = '0;
  logic [5:0]  srcstep, dststep;
  logic [3:0]  cr0;
  logic        rt_we;
  logic [63:0] rt_val;

  always #5 clk = ~clk;

  vfstep_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_vf(cmd_vf), .cmd_vs(cmd_vs),
    .cmd_ms(cmd_ms), .cmd_rc(cmd_rc), .cmd_rt_nz(cmd_rt_nz), .cmd_imm(cmd_imm), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask), .remap_end(remap_end),
    .srcstep(srcstep), .dststep(dststep), .cr0(cr0), .rt_we(rt_we), .rt_val(rt_val)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural reference state
  int m_src = 0, m_dst = 0, m_cr = 0, m_rtwe = 0;
  longint unsigned m_rtval = 0;
  string tag_step = "R1", tag_cr = "R1", tag_rt = "R1";

  function automatic int seek(logic [63:0] m, int lim, int from);
    for (int i = from + 1; i < lim; i++) if (m[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_cr = 0; m_rtwe = 0; m_rtval = 0;
      tag_step = "R1"; tag_cr = "R1"; tag_rt = "R1";
    end else begin
      bit fire;
      int ns, nd, s;
      fire = cmd_valid && cmd_vf && !cmd_vs && !cmd_ms;
      m_rtwe = 0;
      tag_step = "R2"; tag_cr = "R5"; tag_rt = "R7";
      if (fire) begin
        ns = seek(src_mask, int'(vl), m_src);
        nd = seek(dst_mask, int'(vl), m_dst);
        if (ns < 0 || nd < 0) begin
          m_src = 0; m_dst = 0; tag_step = "R4";
        end else begin
          m_src = ns; m_dst = nd; tag_step = "R3";
        end
        if (cmd_rc) begin
          m_cr = (ns < 0 || nd < 0) ? 1 : 0;
          tag_cr = (ns < 0 || nd < 0) ? "R4" : "R6";
          if (cmd_imm >= 1 && cmd_imm <= 4) begin
            s = int'(cmd_imm) - 1;
            if (remap_end[3*s])     m_cr += 2;
            if (remap_end[3*s + 2]) m_cr += 4;
            if (remap_end[3*s + 1]) m_cr += 8;
          end
        end
        if (cmd_rt_nz && (cmd_imm == 5 || cmd_imm == 6)) begin
          m_rtwe = 1;
          m_rtval = (cmd_imm == 5) ? longint'(m_src) : longint'(m_dst);
        end
      end
    end
  end

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag_step, "srcstep", longint'(srcstep), longint'(m_src));
    chk(tag_step, "dststep", longint'(dststep), longint'(m_dst));
    chk(tag_cr,   "cr0",     longint'(cr0),     longint'(m_cr));
    chk(tag_rt,   "rt_we",   longint'(rt_we),   longint'(m_rtwe));
    chk(tag_rt,   "rt_val",  rt_val,            m_rtval);
  endtask

  task automatic drive_random();
    int k;
    k = $urandom % 8;
    cmd_valid = ($urandom % 5) != 0;
    if (k < 6) begin
      cmd_vf = 1; cmd_vs = 0; cmd_ms = 0;      // step command
    end else begin
      {cmd_vf, cmd_vs, cmd_ms} = 3'($urandom % 8);
      if (cmd_vf && !cmd_vs && !cmd_ms) cmd_ms = 1; // R2: a non-step variant
    end
    cmd_rc    = $urandom % 2;
    cmd_rt_nz = $urandom % 2;
    cmd_imm   = 7'($urandom % 9);
    remap_end = 12'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();                       // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();                       // R1 after release, no command
    for (int p = 0; p < 9; p++) begin
      case (p)
        0: begin vl = 64; src_mask = '1; dst_mask = '1; end
        1: begin vl = 0;  src_mask = '1; dst_mask = '1; end
        2: begin vl = 64; src_mask = '1; dst_mask = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}; end
        3: begin vl = 40; src_mask = '0; dst_mask = '1; end
        4: begin vl = 7'($urandom % 65); src_mask = {$urandom, $urandom}; dst_mask = {$urandom, $urandom}; end
        5: begin vl = 64; src_mask = 64'h8000_0000_0000_0001; dst_mask = 64'h8000_0000_0000_0001; end
        6: begin vl = 63; src_mask = 64'h8000_0000_0000_0001; dst_mask = '1; end
        7: begin vl = 17; src_mask = {$urandom, $urandom} | {$urandom, $urandom}; dst_mask = {$urandom, $urandom}; end
        default: begin vl = 64; src_mask = {$urandom, $urandom}; dst_mask = {$urandom, $urandom}; end
      endcase
      for (int c = 0; c < 300; c++) begin
        drive_random();
        if (p == 8 && (c % 20) == 0) begin
          vl = 7'($urandom % 65);
          src_mask = {$urandom, $urandom};
        end
        @(negedge clk);
        compare_all();
      end
    end
    cmd_valid = 0;
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule